// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block watches a bank of general-purpose input pins and turns their activity into interrupt requests. The pins are arranged in 21 groups of up to eight. Every pin has its own 4-bit trigger field that selects a level or an edge condition. A condition that is met latches a pending bit. Software acknowledges it by writing a one to that bit. A per-pin mask decides whether a latched pending bit reaches the single combined interrupt line.

Software sees three word arrays, each with one 32-bit word per group at a stride of 4 bytes. Trigger fields start at offset 0x700, masks at 0x900 and pending bits at 0xA00. Pin p of a group always sits at bit p of its mask and pending words, and at bits 4p+3..4p of its trigger word. Every pin passes through a two-stage synchroniser before detection. A per-group summary output lets an interrupt handler find the active groups: it scans groups from 0 upward and then pins from bit 0 upward.

Top module: `gpint_ctrl`

## Requirements
- R1: The trigger array is decoded at 0x700 + 4g, the mask array at 0x900 + 4g and the pending array at 0xA00 + 4g, for g in 0..20. Pin p of group g is input bit g*8+p. Reads of any other address, or of an address that is not word aligned, return zero, and writes to such addresses change nothing.
- R2: Trigger codes 2 (falling), 3 (rising) and 4 (both edges) set the pin's pending bit once per qualifying edge. The bit is visible on the third rising clock edge after the pin changes.
- R3: Trigger codes 0 (low level) and 1 (high level) set the pending bit on every cycle the level holds. An acknowledge therefore only sticks once the level has gone away.
- R4: Trigger codes 5 to 15 never set a pending bit, whatever the pin does.
- R5: Writing 1 to a pending bit clears it. Writing 0 leaves the bit unchanged.
- R6: A mask bit of 1 blocks its pin. irq_out is high exactly when some pin has pending 1 and mask 0.
- R7: Pending bits latch events while masked. Clearing the mask bit of a pending pin raises irq_out in the cycle after the write.
- R8: When an acknowledge and a new event for the same pin fall in the same cycle, the pending bit stays set.
- R9: grp_active[g] is high exactly when group g has at least one pending bit whose mask bit is 0.
- R10: After reset every trigger field is 0, every mask bit is 1, every pending bit is 0 and irq_out is low.
- R11: A trigger word reads back all 32 written bits. Mask and pending words read bits 31..8 as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 168 | Asynchronous GPIO inputs, group g pin p at bit g*8+p |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read byte address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| grp_active | output | 21 | Per-group flag: an unmasked pending bit exists |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The delicate overlap is an acknowledge write to a pending bit in the same cycle that the detector reports a new event for that pin. The bench times a rising edge so that the write strobe lands on the edge where the event is latched. It then requires the bit to read back as set, and to clear on a later write with no event. A second overlap is an acknowledge during an active level. That write must be overridden, and the bench shows this by reading the pending word after the write.

// File: rtl/gpint_pkg.sv
package gpint_pkg;

    localparam int GP_GROUPS  = 21;
    localparam int GP_PINS    = 8;
    localparam int FIELD_W    = 4;
    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 12;
    localparam int SEL_W      = ADDR_W - 2;

    localparam logic [ADDR_W-1:0] CFG_BASE  = 12'h700;
    localparam logic [ADDR_W-1:0] MASK_BASE = 12'h900;
    localparam logic [ADDR_W-1:0] PEND_BASE = 12'hA00;

    typedef enum logic [FIELD_W-1:0] {
        TRIG_LOW  = 4'd0,
        TRIG_HIGH = 4'd1,
        TRIG_FALL = 4'd2,
        TRIG_RISE = 4'd3,
        TRIG_BOTH = 4'd4
    } trig_e;

    typedef enum logic [1:0] {
        BANK_NONE,
        BANK_CFG,
        BANK_MASK,
        BANK_PEND
    } bank_e;

    typedef struct packed {
        bank_e              bank;
        logic [SEL_W-1:0]   grp;
    } reg_sel_t;

    // Map a byte address to a register bank and group index.
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int ngroups);
        reg_sel_t s;
        logic [ADDR_W-1:0] dc, dm, dp;
        s.bank = BANK_NONE;
        s.grp  = '0;
        dc = a - CFG_BASE;
        dm = a - MASK_BASE;
        dp = a - PEND_BASE;
        if (a[1:0] == 2'b00) begin
            if (int'(dc[ADDR_W-1:2]) < ngroups) begin
                s.bank = BANK_CFG;
                s.grp  = dc[ADDR_W-1:2];
            end else if (int'(dm[ADDR_W-1:2]) < ngroups) begin
                s.bank = BANK_MASK;
                s.grp  = dm[ADDR_W-1:2];
            end else if (int'(dp[ADDR_W-1:2]) < ngroups) begin
                s.bank = BANK_PEND;
                s.grp  = dp[ADDR_W-1:2];
            end
        end
        return s;
    endfunction

    // Decide whether one pin meets its trigger condition this cycle.
    function automatic logic trig_hit(input logic [FIELD_W-1:0] mode,
                                      input logic cur,
                                      input logic prev);
        logic hit;
        case (mode)
            TRIG_LOW:  hit = !cur;
            TRIG_HIGH: hit = cur;
            TRIG_FALL: hit = prev && !cur;
            TRIG_RISE: hit = !prev && cur;
            TRIG_BOTH: hit = prev ^ cur;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpint_sync.sv
module gpint_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/gpint_detect.sv
module gpint_detect
    import gpint_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [PINS-1:0]         level,
    input  logic [PINS*FIELD_W-1:0] cfg,
    output logic [PINS-1:0]         evt
);
    logic [PINS-1:0] level_d;

    always_ff @(posedge clk) begin
        if (rst) level_d <= '0;
        else     level_d <= level;
    end

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        assign evt[p] = trig_hit(cfg[p*FIELD_W +: FIELD_W], level[p], level_d[p]);
    end
endmodule

// File: rtl/gpint_group.sv
module gpint_group
    import gpint_pkg::*;
#(
    parameter int PINS = 8,
    localparam int CFG_W = PINS * FIELD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              mask_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [PINS-1:0]   mask_wdata,
    input  logic [PINS-1:0]   clr,
    input  logic [PINS-1:0]   evt,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [PINS-1:0]   mask_q,
    output logic [PINS-1:0]   pend_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            mask_q <= '1;
            pend_q <= '0;
        end else begin
            if (cfg_we)  cfg_q  <= cfg_wdata;
            if (mask_we) mask_q <= mask_wdata;
            // a fresh event overrides an acknowledge in the same cycle
            pend_q <= (pend_q & ~clr) | evt;
        end
    end
endmodule

// File: rtl/gpint_ctrl.sv
module gpint_ctrl
    import gpint_pkg::*;
#(
    parameter int NUM_GROUPS     = GP_GROUPS,
    parameter int PINS_PER_GROUP = GP_PINS,
    localparam int NPIN  = NUM_GROUPS * PINS_PER_GROUP,
    localparam int CFG_W = PINS_PER_GROUP * FIELD_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NPIN-1:0]       pin_in,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [WORD_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [WORD_W-1:0]     rd_data,
    output logic [NUM_GROUPS-1:0] grp_active,
    output logic                  irq_out
);
    logic [NPIN-1:0]             pin_sync;
    logic [NPIN-1:0]             evt_flat;
    logic [NPIN-1:0]             clr_flat;
    logic [NPIN-1:0]             mask_flat;
    logic [NPIN-1:0]             pend_flat;
    logic [NUM_GROUPS*CFG_W-1:0] cfg_flat;
    reg_sel_t                    wsel;
    reg_sel_t                    rsel;

    assign wsel = decode_addr(wr_addr, NUM_GROUPS);
    assign rsel = decode_addr(rd_addr, NUM_GROUPS);

    gpint_sync #(.WIDTH(NPIN)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic hit;
        assign hit = wr_en && (int'(wsel.grp) == g);
        assign clr_flat[g*PINS_PER_GROUP +: PINS_PER_GROUP] =
            (hit && wsel.bank == BANK_PEND) ? wr_data[PINS_PER_GROUP-1:0] : '0;

        gpint_detect #(.PINS(PINS_PER_GROUP)) det_i (
            .clk   (clk),
            .rst   (rst),
            .level (pin_sync[g*PINS_PER_GROUP +: PINS_PER_GROUP]),
            .cfg   (cfg_flat[g*CFG_W +: CFG_W]),
            .evt   (evt_flat[g*PINS_PER_GROUP +: PINS_PER_GROUP])
        );

        gpint_group #(.PINS(PINS_PER_GROUP)) grp_i (
            .clk        (clk),
            .rst        (rst),
            .cfg_we     (hit && wsel.bank == BANK_CFG),
            .mask_we    (hit && wsel.bank == BANK_MASK),
            .cfg_wdata  (wr_data[CFG_W-1:0]),
            .mask_wdata (wr_data[PINS_PER_GROUP-1:0]),
            .clr        (clr_flat[g*PINS_PER_GROUP +: PINS_PER_GROUP]),
            .evt        (evt_flat[g*PINS_PER_GROUP +: PINS_PER_GROUP]),
            .cfg_q      (cfg_flat[g*CFG_W +: CFG_W]),
            .mask_q     (mask_flat[g*PINS_PER_GROUP +: PINS_PER_GROUP]),
            .pend_q     (pend_flat[g*PINS_PER_GROUP +: PINS_PER_GROUP])
        );

        assign grp_active[g] = |(pend_flat[g*PINS_PER_GROUP +: PINS_PER_GROUP] &
                                 ~mask_flat[g*PINS_PER_GROUP +: PINS_PER_GROUP]);
    end

    assign irq_out = |grp_active;

    always_comb begin
        rd_data = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (int'(rsel.grp) == g) begin
                case (rsel.bank)
                    BANK_CFG:  rd_data = WORD_W'(cfg_flat[g*CFG_W +: CFG_W]);
                    BANK_MASK: rd_data = WORD_W'(mask_flat[g*PINS_PER_GROUP +: PINS_PER_GROUP]);
                    BANK_PEND: rd_data = WORD_W'(pend_flat[g*PINS_PER_GROUP +: PINS_PER_GROUP]);
                    default:   rd_data = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpint_checker.sv
module gpint_checker
    import gpint_pkg::*;
#(
    parameter int NUM_GROUPS     = GP_GROUPS,
    parameter int PINS_PER_GROUP = GP_PINS,
    localparam int NPIN  = NUM_GROUPS * PINS_PER_GROUP
) (
    input logic                          clk,
    input logic                          rst,
    input logic [NPIN-1:0]               evt_flat,
    input logic [NPIN-1:0]               clr_flat,
    input logic [NPIN-1:0]               mask_flat,
    input logic [NPIN-1:0]               pend_flat,
    input logic [NPIN*FIELD_W-1:0]       cfg_flat,
    input logic [NUM_GROUPS-1:0]         grp_active,
    input logic                          irq_out
);
    assert_event_latches_R2: assert property (@(posedge clk) disable iff (rst)
        (evt_flat != '0) |=> ((pend_flat & $past(evt_flat)) == $past(evt_flat)));

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
        ((clr_flat & ~evt_flat) != '0) |=> ((pend_flat & $past(clr_flat & ~evt_flat)) == '0));

    assert_no_silent_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (pend_flat != '0) |=> ((($past(pend_flat) & ~pend_flat) & ~$past(clr_flat)) == '0));

    assert_irq_has_source_R6: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> ((pend_flat & ~mask_flat) != '0));

    assert_source_drives_irq_R6: assert property (@(posedge clk) disable iff (rst)
        ((pend_flat & ~mask_flat) != '0) |-> irq_out);

    assert_summary_consistent_R9: assert property (@(posedge clk) disable iff (rst)
        (grp_active != '0) |-> irq_out);

    for (genvar i = 0; i < NPIN; i++) begin : g_res
        assert_reserved_quiet_R4: assert property (@(posedge clk) disable iff (rst)
            (cfg_flat[i*FIELD_W +: FIELD_W] > 4'd4) |-> !evt_flat[i]);
    end
endmodule

bind gpint_ctrl gpint_checker #(
    .NUM_GROUPS     (NUM_GROUPS),
    .PINS_PER_GROUP (PINS_PER_GROUP)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .evt_flat   (evt_flat),
    .clr_flat   (clr_flat),
    .mask_flat  (mask_flat),
    .pend_flat  (pend_flat),
    .cfg_flat   (cfg_flat),
    .grp_active (grp_active),
    .irq_out    (irq_out)
);

// File: tb/gpint_ctrl_tb_top.sv
module gpint_ctrl_tb_top;
    localparam int NG = 21;
    localparam int NP = NG * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pins = '1;
    logic          wr_en = 1'b0;
    logic [11:0]   wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [11:0]   rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NG-1:0] grp_active;
    logic          irq_out;
    int            n_cmp = 0;
    int            n_bad = 0;
    bit            done = 1'b0;

    always #5 clk = ~clk;

    gpint_ctrl dut_i (
        .clk        (clk),
        .rst        (rst),
        .pin_in     (pins),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .grp_active (grp_active),
        .irq_out    (irq_out)
    );

    function automatic logic [11:0] a_cfg(input int g);  return 12'h700 + 12'(g * 4); endfunction
    function automatic logic [11:0] a_mask(input int g); return 12'h900 + 12'(g * 4); endfunction
    function automatic logic [11:0] a_pend(input int g); return 12'hA00 + 12'(g * 4); endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic t_reset;
        tick(3);
        rd_chk("R10 cfg reset", a_cfg(0), 32'h0);
        rd_chk("R10 mask reset", a_mask(5), 32'hFF);
        rd_chk("R10 pend reset", a_pend(20), 32'h0);
        chk("R10 irq reset", {31'b0, irq_out}, 32'h0);
        rst = 1'b0;
        tick(5);
        for (int g = 0; g < NG; g++) wr(a_pend(g), 32'hFF);
        tick(2);
        rd_chk("R10 pend settled", a_pend(0), 32'h0);
        chk("R10 summary idle", 32'(grp_active), 32'h0);
    endtask

    task automatic t_rising;
        wr(a_cfg(2), 32'h0000_3000);
        wr(a_mask(2), 32'hF7);
        pins[2*8+3] = 1'b0;
        tick(4);
        rd_chk("R2 rising ignores fall", a_pend(2), 32'h0);
        pins[2*8+3] = 1'b1;
        tick(2);
        rd_chk("R2 not before third edge", a_pend(2), 32'h0);
        tick(1);
        rd_chk("R2 rising sets bit 3", a_pend(2), 32'h08);
        chk("R6 irq from unmasked", {31'b0, irq_out}, 32'h1);
        chk("R9 summary group 2", 32'(grp_active), 32'h4);
        wr(a_pend(2), 32'h08);
        rd_chk("R5 ack clears", a_pend(2), 32'h0);
        chk("R6 irq drops", {31'b0, irq_out}, 32'h0);
        wr(a_mask(2), 32'hFF);
    endtask

    task automatic t_falling_masked;
        wr(a_cfg(0), 32'h0000_0002);
        pins[0] = 1'b0;
        tick(3);
        rd_chk("R7 latch while masked", a_pend(0), 32'h01);
        chk("R6 masked no irq", {31'b0, irq_out}, 32'h0);
        wr(a_mask(0), 32'hFE);
        chk("R7 unmask raises irq", {31'b0, irq_out}, 32'h1);
        chk("R9 summary group 0", 32'(grp_active), 32'h1);
        wr(a_pend(0), 32'h00);
        rd_chk("R5 write zero keeps", a_pend(0), 32'h01);
        wr(a_pend(0), 32'h01);
        rd_chk("R2 falling fires once", a_pend(0), 32'h0);
        wr(a_mask(0), 32'hFF);
        pins[0] = 1'b1;
        tick(4);
    endtask

    task automatic t_both;
        wr(a_cfg(20), 32'h4000_0000);
        pins[20*8+7] = 1'b0;
        tick(3);
        rd_chk("R2 both edges fall", a_pend(20), 32'h80);
        wr(a_pend(20), 32'h80);
        pins[20*8+7] = 1'b1;
        tick(3);
        rd_chk("R2 both edges rise", a_pend(20), 32'h80);
        wr(a_pend(20), 32'h80);
        rd_chk("R1 group 20 cleared", a_pend(20), 32'h0);
    endtask

    task automatic t_levels;
        wr(a_cfg(7), 32'h0000_0010);
        tick(1);
        rd_chk("R3 high level pends", a_pend(7), 32'h02);
        wr(a_pend(7), 32'h02);
        rd_chk("R3 ack ignored while high", a_pend(7), 32'h02);
        pins[7*8+1] = 1'b0;
        tick(3);
        wr(a_pend(7), 32'h02);
        tick(1);
        rd_chk("R3 ack sticks after level", a_pend(7), 32'h0);
        pins[7*8+2] = 1'b0;
        tick(3);
        wr(a_pend(7), 32'h04);
        rd_chk("R3 low level reasserts", a_pend(7), 32'h04);
        pins[7*8+2] = 1'b1;
        tick(3);
        wr(a_pend(7), 32'h04);
        rd_chk("R3 low level released", a_pend(7), 32'h0);
    endtask

    task automatic t_reserved;
        wr(a_cfg(10), 32'h0050_0000);
        pins[10*8+5] = 1'b0;
        tick(4);
        pins[10*8+5] = 1'b1;
        tick(4);
        rd_chk("R4 code 5 silent", a_pend(10), 32'h0);
        wr(a_cfg(10), 32'h00F0_0000);
        pins[10*8+5] = 1'b0;
        tick(4);
        rd_chk("R4 code 15 silent", a_pend(10), 32'h0);
        pins[10*8+5] = 1'b1;
        tick(4);
    endtask

    task automatic t_collision;
        wr(a_cfg(3), 32'h0000_0003);
        pins[3*8] = 1'b0;
        tick(4);
        pins[3*8] = 1'b1;
        tick(2);
        wr(a_pend(3), 32'h01);
        rd_chk("R8 event beats ack", a_pend(3), 32'h01);
        wr(a_pend(3), 32'h01);
        rd_chk("R8 later ack clears", a_pend(3), 32'h0);
    endtask

    task automatic t_summary;
        wr(a_cfg(4), 32'h0000_0030);
        wr(a_cfg(9), 32'h0000_0300);
        wr(a_mask(4), 32'hFD);
        pins[4*8+1] = 1'b0;
        pins[9*8+2] = 1'b0;
        tick(4);
        pins[4*8+1] = 1'b1;
        pins[9*8+2] = 1'b1;
        tick(3);
        chk("R9 only unmasked group", 32'(grp_active), 32'h10);
        wr(a_mask(9), 32'hFB);
        chk("R9 two groups", 32'(grp_active), 32'h210);
        wr(a_pend(4), 32'h02);
        chk("R9 group 4 acked", 32'(grp_active), 32'h200);
        wr(a_pend(9), 32'h04);
        chk("R6 all quiet", {31'b0, irq_out}, 32'h0);
        wr(a_mask(4), 32'hFF);
        wr(a_mask(9), 32'hFF);
    endtask

    task automatic t_regs;
        wr(a_cfg(9), 32'hDEAD_BEEF);
        rd_chk("R11 cfg full word", a_cfg(9), 32'hDEAD_BEEF);
        wr(a_mask(9), 32'hFFFF_FF00);
        rd_chk("R11 mask upper zero", a_mask(9), 32'h0);
        wr(a_mask(9), 32'hFF);
        wr(12'h954, 32'h0);
        rd_chk("R1 out of range read", 12'h954, 32'h0);
        rd_chk("R1 unaligned read", 12'h902, 32'h0);
        wr(12'h902, 32'h0);
        rd_chk("R1 unaligned write ignored", a_mask(0), 32'hFF);
        rd_chk("R1 last mask intact", a_mask(20), 32'hFF);
    endtask

    initial begin
        t_reset;
        t_rising;
        t_falling_masked;
        t_both;
        t_levels;
        t_reserved;
        t_collision;
        t_summary;
        t_regs;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %h expected %h", 32'h0, 32'h1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule